// File: doc/BRIEF.md
# Command Response Checker

This block sits behind the command-line deserialiser of a memory-card host controller. Once a response has been shifted in, the deserialiser presents its bits together with a one-cycle `rsp_valid` strobe. The checker then validates the frame against the configuration of the command just issued. It recomputes the 7-bit CRC and compares the echoed command index with the programmed one. It can also scan the card status field for error bits, using either the memory-card (R1) layout or the I/O-card (R5) layout. Each failed check raises its own one-cycle error flag.

The checker also produces the command-complete event. This event is qualified by a status enable and can be forced off by a mask bit. That lets software suppress the completion interrupt when the hardware content check is doing the work. For responses that signal busy on DAT0, completion is held back and a `busy_wait` level is shown until the card releases the line. Commands that expect no response complete one cycle after the issue pulse.

Top module: `resp_checker`

## Requirements
- R1: `cfg_rsp_kind` selects the response type: 2'b00 none, 2'b01 136-bit, 2'b10 48-bit, 2'b11 48-bit with DAT0 busy. A `rsp_valid` strobe while the kind is 2'b00 raises no error flag and no completion.
- R2: A `cmd_issue` pulse with kind 2'b00 gives a `cmd_done` pulse in the next cycle, with no error flag. An issue pulse with any other kind has no effect on the outputs.
- R3: For 48-bit kinds the CRC7 (x^7+x^3+1, zero seed) is computed over frame bits [47:8] and compared with bits [7:1]. When the CRC check is enabled and the values differ, `err_crc` pulses in the cycle after the strobe.
- R4: For the 136-bit kind the CRC7 is computed over bits [127:8] and compared with bits [7:1]. The index check is never applied to this kind.
- R5: With `cfg_crc_chk` low, `err_crc` stays low whatever the received CRC bits are.
- R6: With `cfg_idx_chk` high on a 48-bit kind, `err_idx` pulses when frame bits [45:40] differ from `cfg_cmd_idx`. With it low, those bits are ignored.
- R7: In R1 mode (`cfg_stat_sdio`=0) the status is frame bits [39:8]. Any of status bits 31, 30, 29, 26, 25, 23, 21, 20 or 19 set raises `err_stat`. Other status bits do not.
- R8: In R5 mode (`cfg_stat_sdio`=1) the flags byte is frame bits [23:16]. Any of its bits 7, 3, 1 or 0 set raises `err_stat`. Other bits, including R1 positions, do not.
- R9: With `cfg_stat_chk` low, `err_stat` stays low and the R1/R5 select has no effect. The content check applies only to the 48-bit kinds.
- R10: `cmd_done` only pulses when `cfg_done_en` is 1 and `cfg_done_mask` is 0. A mask of 1 suppresses it regardless of the enable.
- R11: After a kind 2'b11 response, `busy_wait` is high from the next cycle until `dat0_busy` is sampled low. `cmd_done` pulses in the cycle after that sample, and new strobes are ignored while busy.
- R12: For kinds 2'b01 and 2'b10, `cmd_done` pulses in the same cycle as the error flags, one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rsp_kind | input | 2 | Expected response type |
| cfg_crc_chk | input | 1 | Enable the CRC comparison |
| cfg_idx_chk | input | 1 | Enable the index comparison |
| cfg_stat_chk | input | 1 | Enable the card status error scan |
| cfg_stat_sdio | input | 1 | 0: R1 status layout, 1: R5 flags layout |
| cfg_done_mask | input | 1 | Force command-complete off |
| cfg_done_en | input | 1 | Command-complete status enable |
| cfg_cmd_idx | input | IDX_W | Index of the issued command |
| cmd_issue | input | 1 | One-cycle pulse when a command is sent |
| rsp_valid | input | 1 | One-cycle strobe: response bits are valid |
| rsp_frame | input | 127 | Response bits [127:1]; 48-bit responses use [47:1] |
| dat0_busy | input | 1 | Card holds DAT0 low (busy) |
| err_crc | output | 1 | CRC mismatch pulse |
| err_idx | output | 1 | Index mismatch pulse |
| err_stat | output | 1 | Card status error pulse |
| cmd_done | output | 1 | Gated command-complete pulse |
| busy_wait | output | 1 | Waiting for DAT0 busy release |

## Verification
The assertions check several rules on every cycle:
- Disabled checks never raise their flags.
- A mask or a cleared enable blocks completion.
- Flags only follow an accepted response.
- A busy wait holds while DAT0 stays busy and ends with a completion once DAT0 is free.
- A no-response issue completes at the next edge.

The CRC values, the exact R1 and R5 bit masks, the index comparison and the 136-bit coverage range can only be shown by the bench's frames. The bench builds those frames with its own polynomial division and compares the flags against expected values.

// File: rtl/rc_pkg.sv
package rc_pkg;

  localparam int FRAME_HI  = 127;
  localparam int SHORT_HI  = 47;
  localparam int CRC_W     = 7;
  localparam int CRC_LO    = CRC_W + 1;
  localparam int STAT_W    = 32;
  localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

  localparam logic [STAT_W-1:0] R1_ERR_MASK = 32'hE6B8_0000;
  localparam logic [7:0]        R5_ERR_MASK = 8'h8B;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_kind_e;

  // Serial CRC7 over frame bits hi down to CRC_LO, zero seed.
  function automatic logic [CRC_W-1:0] crc7_span(input logic [FRAME_HI:1] f, input int hi);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = FRAME_HI; i >= CRC_LO; i--) begin
      if (i <= hi) begin
        fb = f[i] ^ c[CRC_W-1];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
      end
    end
    return c;
  endfunction

  // Card status scan: R1 word or R5 flags byte (status bits 15:8).
  function automatic logic status_has_error(input logic [STAT_W-1:0] st, input logic sdio);
    if (sdio) return |(st[15:8] & R5_ERR_MASK);
    return |(st & R1_ERR_MASK);
  endfunction

endpackage

// File: rtl/rc_frame_check.sv
module rc_frame_check
  import rc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [FRAME_HI:1] frame,
  input  logic [1:0]        kind,
  input  logic              crc_en,
  input  logic              idx_en,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              crc_bad,
  output logic              idx_bad
);
  localparam int IDX_LO = SHORT_HI - 1 - IDX_W;

  logic             is_long;
  logic [CRC_W-1:0] crc_calc;
  logic [CRC_W-1:0] crc_rx;
  logic [IDX_W-1:0] idx_rx;

  always_comb begin
    is_long  = (kind == RSP_LONG);
    crc_calc = is_long ? crc7_span(frame, FRAME_HI) : crc7_span(frame, SHORT_HI);
    crc_rx   = frame[CRC_W:1];
    idx_rx   = frame[IDX_LO+IDX_W-1:IDX_LO];
    crc_bad  = crc_en && (crc_calc != crc_rx);
    idx_bad  = idx_en && !is_long && (idx_rx != cmd_idx);
  end
endmodule

// File: rtl/rc_status_check.sv
module rc_status_check
  import rc_pkg::*;
(
  input  logic [STAT_W-1:0] status,
  input  logic [1:0]        kind,
  input  logic              stat_en,
  input  logic              sdio,
  output logic              stat_bad
);
  always_comb begin
    stat_bad = stat_en && kind[1] && status_has_error(status, sdio);
  end
endmodule

// File: rtl/rc_done_seq.sv
module rc_done_seq
  import rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] kind,
  input  logic       issue,
  input  logic       rsp_valid,
  input  logic       dat0_busy,
  output logic       rsp_accept,
  output logic       done_raw,
  output logic       busy_q
);
  logic busy_d;

  always_comb begin
    rsp_accept = rsp_valid && (kind != RSP_NONE) && !busy_q;
    done_raw   = (!busy_q && issue && kind == RSP_NONE)
              || (rsp_accept && kind != RSP_BUSY)
              || (busy_q && !dat0_busy);
    busy_d     = busy_q ? dat0_busy : (rsp_accept && kind == RSP_BUSY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end
endmodule

// File: rtl/resp_checker.sv
module resp_checker
  import rc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_rsp_kind,
  input  logic              cfg_crc_chk,
  input  logic              cfg_idx_chk,
  input  logic              cfg_stat_chk,
  input  logic              cfg_stat_sdio,
  input  logic              cfg_done_mask,
  input  logic              cfg_done_en,
  input  logic [IDX_W-1:0]  cfg_cmd_idx,
  input  logic              cmd_issue,
  input  logic              rsp_valid,
  input  logic [FRAME_HI:1] rsp_frame,
  input  logic              dat0_busy,
  output logic              err_crc,
  output logic              err_idx,
  output logic              err_stat,
  output logic              cmd_done,
  output logic              busy_wait
);
  // Named internal events, visible to the bound checker.
  logic crc_bad, idx_bad, stat_bad;
  logic rsp_accept, done_raw, done_gated;

  rc_frame_check #(.IDX_W(IDX_W)) u_frame (
    .frame   (rsp_frame),
    .kind    (cfg_rsp_kind),
    .crc_en  (cfg_crc_chk),
    .idx_en  (cfg_idx_chk),
    .cmd_idx (cfg_cmd_idx),
    .crc_bad (crc_bad),
    .idx_bad (idx_bad)
  );

  rc_status_check u_status (
    .status   (rsp_frame[STAT_W+CRC_W:CRC_LO]),
    .kind     (cfg_rsp_kind),
    .stat_en  (cfg_stat_chk),
    .sdio     (cfg_stat_sdio),
    .stat_bad (stat_bad)
  );

  rc_done_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (cfg_rsp_kind),
    .issue      (cmd_issue),
    .rsp_valid  (rsp_valid),
    .dat0_busy  (dat0_busy),
    .rsp_accept (rsp_accept),
    .done_raw   (done_raw),
    .busy_q     (busy_wait)
  );

  assign done_gated = done_raw && cfg_done_en && !cfg_done_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_crc  <= 1'b0;
      err_idx  <= 1'b0;
      err_stat <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      err_crc  <= rsp_accept && crc_bad;
      err_idx  <= rsp_accept && idx_bad;
      err_stat <= rsp_accept && stat_bad;
      cmd_done <= done_gated;
    end
  end
endmodule

// File: rtl/resp_checker_sva.sv
module resp_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_rsp_kind,
  input logic       cfg_crc_chk,
  input logic       cfg_idx_chk,
  input logic       cfg_stat_chk,
  input logic       cfg_done_mask,
  input logic       cfg_done_en,
  input logic       cmd_issue,
  input logic       rsp_valid,
  input logic       dat0_busy,
  input logic       rsp_accept,
  input logic       err_crc,
  input logic       err_idx,
  input logic       err_stat,
  input logic       cmd_done,
  input logic       busy_wait
);
  a_r1_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cfg_rsp_kind == 2'b00 && !cmd_issue && !busy_wait)
    |=> (!cmd_done && !err_crc && !err_idx && !err_stat));

  a_r2_none_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cfg_rsp_kind == 2'b00 && !busy_wait && cfg_done_en && !cfg_done_mask)
    |=> cmd_done);

  a_r3_flags_need_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_accept |=> (!err_crc && !err_idx && !err_stat));

  a_r5_crc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_crc_chk |=> !err_crc);

  a_r6_idx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_idx_chk |=> !err_idx);

  a_r9_stat_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_stat_chk |=> !err_stat);

  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done_mask || !cfg_done_en) |=> !cmd_done);

  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_wait && dat0_busy) |=> (busy_wait && !cmd_done));

  a_r11_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_wait && !dat0_busy && cfg_done_en && !cfg_done_mask) |=> (!busy_wait && cmd_done));
endmodule

bind resp_checker resp_checker_sva u_resp_checker_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rsp_kind  (cfg_rsp_kind),
  .cfg_crc_chk   (cfg_crc_chk),
  .cfg_idx_chk   (cfg_idx_chk),
  .cfg_stat_chk  (cfg_stat_chk),
  .cfg_done_mask (cfg_done_mask),
  .cfg_done_en   (cfg_done_en),
  .cmd_issue     (cmd_issue),
  .rsp_valid     (rsp_valid),
  .dat0_busy     (dat0_busy),
  .rsp_accept    (rsp_accept),
  .err_crc       (err_crc),
  .err_idx       (err_idx),
  .err_stat      (err_stat),
  .cmd_done      (cmd_done),
  .busy_wait     (busy_wait)
);

// File: tb/resp_checker_bench.sv
module resp_checker_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_rsp_kind = 2'b00;
  logic         cfg_crc_chk = 1'b0, cfg_idx_chk = 1'b0, cfg_stat_chk = 1'b0, cfg_stat_sdio = 1'b0;
  logic         cfg_done_mask = 1'b0, cfg_done_en = 1'b1;
  logic [5:0]   cfg_cmd_idx = 6'd0;
  logic         cmd_issue = 1'b0, rsp_valid = 1'b0, dat0_busy = 1'b0;
  logic [127:1] rsp_frame = '0;
  logic         err_crc, err_idx, err_stat, cmd_done, busy_wait;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  resp_checker u_resp_checker (
    .clk(clk), .rst_n(rst_n), .cfg_rsp_kind(cfg_rsp_kind), .cfg_crc_chk(cfg_crc_chk),
    .cfg_idx_chk(cfg_idx_chk), .cfg_stat_chk(cfg_stat_chk), .cfg_stat_sdio(cfg_stat_sdio),
    .cfg_done_mask(cfg_done_mask), .cfg_done_en(cfg_done_en), .cfg_cmd_idx(cfg_cmd_idx),
    .cmd_issue(cmd_issue), .rsp_valid(rsp_valid), .rsp_frame(rsp_frame), .dat0_busy(dat0_busy),
    .err_crc(err_crc), .err_idx(err_idx), .err_stat(err_stat), .cmd_done(cmd_done),
    .busy_wait(busy_wait)
  );

  // CRC7 as the remainder of msg * x^7 divided by x^7+x^3+1 (0x89).
  function automatic logic [6:0] div_crc(input logic [119:0] msg, input int n);
    logic [126:0] m;
    m = '0;
    for (int k = 0; k < n; k++) m[k+7] = msg[k];
    for (int i = n + 6; i >= 7; i--)
      if (m[i])
        for (int b = 0; b <= 7; b++) m[i-7+b] = m[i-7+b] ^ (8'h89 >> b & 8'h01) != 0;
    return m[6:0];
  endfunction

  function automatic logic [127:1] mk_short(input logic [5:0] idx, input logic [31:0] st, input logic bad);
    logic [127:1] f;
    logic [39:0]  body;
    body = {2'b00, idx, st};
    f = '0;
    f[47:8] = body;
    f[7:1]  = div_crc({80'd0, body}, 40) ^ {6'd0, bad};
    return f;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // One response strobe, outputs sampled one negedge later.
  task automatic send(input logic [1:0] kind, input logic [127:1] f);
    @(negedge clk);
    cfg_rsp_kind = kind;
    rsp_frame    = f;
    rsp_valid    = 1'b1;
    @(negedge clk);
    rsp_valid    = 1'b0;
  endtask

  typedef struct packed {
    logic        crc_en;
    logic        idx_en;
    logic        st_en;
    logic        sdio;
    logic [5:0]  cmd;
    logic [5:0]  ridx;
    logic [31:0] stat;
    logic        bad;
    logic [2:0]  exp;   // {crc, idx, stat}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd17, 6'd17, 32'h0000_0900, 1'b0, 3'b000}, // R3 clean
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd17, 6'd17, 32'h0000_0900, 1'b1, 3'b100}, // R3 bad crc
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd17, 6'd18, 32'h0000_0900, 1'b0, 3'b010}, // R6 mismatch
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'd17, 6'd18, 32'h0000_0900, 1'b0, 3'b000}, // R6 off
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd7,  6'd7,  32'h8000_0000, 1'b0, 3'b001}, // R7 bit31
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd7,  6'd7,  32'h0008_0000, 1'b0, 3'b001}, // R7 bit19
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd7,  6'd7,  32'h0200_0000, 1'b0, 3'b001}, // R7 bit25
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'd7,  6'd7,  32'h0844_0000, 1'b0, 3'b000}, // R7 27,22,18 clean
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd52, 6'd52, 32'h0000_8000, 1'b0, 3'b001}, // R8 flag7
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd52, 6'd52, 32'h0000_0100, 1'b0, 3'b001}, // R8 flag0
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd52, 6'd52, 32'h0000_7400, 1'b0, 3'b000}, // R8 flags 6,5,4,2
    '{1'b1, 1'b1, 1'b1, 1'b1, 6'd52, 6'd52, 32'hE6B8_00FF, 1'b0, 3'b000}, // R8 R1 bits ignored
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'd3,  6'd3,  32'hFFFF_FFFF, 1'b0, 3'b000}, // R9 scan off
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'd3,  6'd3,  32'h0000_0000, 1'b1, 3'b000}  // R5 crc off
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:1] lf;
    logic [119:0] body;
    repeat (3) @(negedge clk);
    chk("reset outputs", {27'd0, err_crc, err_idx, err_stat, cmd_done, busy_wait}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 R5 R6 R7 R8 R9 flags and R12 completion timing.
    for (int v = 0; v < NV; v++) begin
      cfg_crc_chk = VECS[v].crc_en; cfg_idx_chk = VECS[v].idx_en;
      cfg_stat_chk = VECS[v].st_en; cfg_stat_sdio = VECS[v].sdio;
      cfg_cmd_idx = VECS[v].cmd;
      send(2'b10, mk_short(VECS[v].ridx, VECS[v].stat, VECS[v].bad));
      chk($sformatf("R3/R5-R9 flags vector %0d", v), {29'd0, err_crc, err_idx, err_stat}, {29'd0, VECS[v].exp});
      chk($sformatf("R12 done vector %0d", v), {31'd0, cmd_done}, 32'd1);
      @(negedge clk);
      chk("R12 done single pulse", {28'd0, cmd_done, err_crc, err_idx, err_stat}, 32'd0);
    end

    // R3 known-good literal frame: index 0, argument 0, crc 0x4A.
    cfg_crc_chk = 1'b1; cfg_idx_chk = 1'b1; cfg_stat_chk = 1'b0; cfg_cmd_idx = 6'd0;
    send(2'b10, {80'd0, 48'h40_0000_0000_95} >> 1);
    chk("R3 literal crc", {31'd0, err_crc}, 32'd0);

    // R4 long frame: good crc, index bits differ but are not checked.
    body = 120'h3F_1234_5678_9ABC_DEF0_0246_8ACE_1357;
    lf = '0; lf[127:8] = body; lf[7:1] = div_crc(body, 120);
    cfg_cmd_idx = 6'd2; cfg_stat_chk = 1'b1;
    send(2'b01, lf);
    chk("R4 long good", {29'd0, err_crc, err_idx, err_stat}, 32'd0);
    chk("R4 long done", {31'd0, cmd_done}, 32'd1);
    lf[127] = ~lf[127];
    send(2'b01, lf);
    chk("R4 long top bit covered", {29'd0, err_crc, err_idx, err_stat}, 32'b100);

    // R9: long kind never scans status even with error bits present.
    lf = '0; lf[39:8] = 32'hFFFF_FFFF; lf[7:1] = div_crc({88'd0, 32'hFFFF_FFFF}, 120);
    send(2'b01, lf);
    chk("R9 long no scan", {31'd0, err_stat}, 32'd0);

    // R1: strobe with kind 00 does nothing.
    send(2'b00, mk_short(6'd9, 32'hFFFF_FFFF, 1'b1));
    chk("R1 none strobe", {28'd0, err_crc, err_idx, err_stat, cmd_done}, 32'd0);

    // R2: no-response issue completes next cycle; other kinds ignore issue.
    @(negedge clk); cfg_rsp_kind = 2'b00; cmd_issue = 1'b1;
    @(negedge clk); cmd_issue = 1'b0;
    chk("R2 issue done", {28'd0, cmd_done, err_crc, err_idx, err_stat}, 32'b1000);
    @(negedge clk); cfg_rsp_kind = 2'b10; cmd_issue = 1'b1;
    @(negedge clk); cmd_issue = 1'b0;
    chk("R2 issue ignored", {31'd0, cmd_done}, 32'd0);

    // R10: mask and enable gating.
    cfg_done_mask = 1'b1; cfg_done_en = 1'b1; cfg_cmd_idx = 6'd5;
    send(2'b10, mk_short(6'd5, 32'd0, 1'b0));
    chk("R10 mask suppresses", {31'd0, cmd_done}, 32'd0);
    cfg_done_mask = 1'b0; cfg_done_en = 1'b0;
    send(2'b10, mk_short(6'd5, 32'd0, 1'b0));
    chk("R10 enable off", {31'd0, cmd_done}, 32'd0);
    cfg_done_en = 1'b1;

    // R11: busy response.
    dat0_busy = 1'b1;
    send(2'b11, mk_short(6'd5, 32'd0, 1'b0));
    chk("R11 busy entered", {30'd0, busy_wait, cmd_done}, 32'b10);
    send(2'b11, mk_short(6'd5, 32'd0, 1'b1));
    chk("R11 strobe ignored while busy", {29'd0, err_crc, busy_wait, cmd_done}, 32'b010);
    repeat (3) @(negedge clk);
    chk("R11 busy held", {30'd0, busy_wait, cmd_done}, 32'b10);
    dat0_busy = 1'b0;
    @(negedge clk);
    chk("R11 release done", {30'd0, busy_wait, cmd_done}, 32'b01);
    @(negedge clk);
    chk("R11 idle after", {30'd0, busy_wait, cmd_done}, 32'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule